// File: doc/BRIEF.md
# Buffered UART Transmitter with Level Threshold and Break

This block is the transmit half of a UART. Characters are pushed into a 16-entry FIFO one per clock through a write strobe. A shifter takes them one at a time and sends them on `txd` with the configured frame. A frame is one start bit, 5 to 8 data bits sent least significant bit first, an optional even or odd parity bit, and one or two stop bits. Every bit lasts `baud_div + 1` clocks. When the FIFO still holds data as the last stop bit ends, the next start bit follows with no idle gap.

Software-facing state is brought out as plain signals. The fill level lets a writer compute free space as `DEPTH - level`. A drained flag and a below-threshold flag feed one interrupt line through two enables. A sticky flag records writes that were dropped because the FIFO was full. The transmit enable pauses the output without losing queued data. The FIFO clear discards queued data. The break control holds the line low, and after a break the line stays high for at least one bit time before the next frame starts.

Top module: `uart_tx_path`

## Requirements
- R1: After reset, `txd` is 1, `level` is 0, `empty_st` is 1 and `ovf_st` is 0.
- R2: A frame is a start bit (0), then `char_len`+5 data bits LSB first (`char_len` code 0..3 gives 5..8 bits), then a parity bit when `par_en`=1, then one stop bit (1) when `two_stop`=0 or two when `two_stop`=1. The parity bit is the XOR of the sent data bits, inverted when `par_odd`=1. Each bit lasts `baud_div`+1 clocks. With data waiting, consecutive start bits are exactly (frame bits)×(`baud_div`+1) clocks apart.
- R3: `level` gives the number of characters held in the FIFO (0 to DEPTH). It rises on the clock edge that takes a write and falls on the edge where the shifter takes a character.
- R4: While `tx_en`=0, no new frame starts and the FIFO contents are kept. A frame already under way completes. Setting `tx_en` again resumes transmission with the held characters.
- R5: While `brk`=1, `txd` is 0 and no frame starts.
- R6: After `brk` returns to 0, `txd` stays 1 for at least `baud_div`+1 clocks before the next start bit.
- R7: A `fifo_clr` pulse leaves `level` at 0 on the next edge and discards unsent characters. It takes priority over a write in the same cycle.
- R8: A write while `level` equals DEPTH is dropped and sets `ovf_st`. `ovf_st` stays set until an `ovf_clr` pulse.
- R9: `empty_st` is 1 only when the FIFO is empty and the shifter is idle. It stays 0 while the last character is still being sent.
- R10: `below_st` is 1 exactly when `level` < `thresh`.
- R11: `irq` = (`empty_st` AND `mask_empty`) OR (`below_st` AND `mask_below`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Push `wr_data` into the FIFO |
| wr_data | input | 8 | Character to queue |
| fifo_clr | input | 1 | Discard all queued characters |
| ovf_clr | input | 1 | Clear the sticky overflow flag |
| tx_en | input | 1 | Allow new frames to start |
| brk | input | 1 | Force the line low |
| baud_div | input | DIV_W | Clocks per bit minus one |
| char_len | input | 2 | Data bits minus five |
| par_en | input | 1 | Append a parity bit |
| par_odd | input | 1 | Odd parity when set, even otherwise |
| two_stop | input | 1 | Two stop bits when set |
| thresh | input | $clog2(DEPTH+1) | Level threshold for `below_st` |
| mask_empty | input | 1 | Route `empty_st` to `irq` |
| mask_below | input | 1 | Route `below_st` to `irq` |
| txd | output | 1 | Serial output, idle high |
| level | output | $clog2(DEPTH+1) | FIFO fill level |
| empty_st | output | 1 | FIFO and shifter both idle |
| below_st | output | 1 | Level under threshold |
| ovf_st | output | 1 | Sticky dropped-write flag |
| irq | output | 1 | Masked interrupt request |

## Verification
`level`, `empty_st`, `below_st`, `ovf_st` and `irq` are decoded from registers, so each one is due on the first clock edge after the write, clear or take that changes it. The bench reads them at the falling edge that follows. `txd` runs one register behind the shifter state. The bench therefore does not predict its edges: it finds each start bit on a falling edge of the line, then samples every later bit in its centre at multiples of `baud_div`+1 clocks. This makes the data check independent of that one-cycle offset. The spacing between start bits is compared exactly. The gap after a break only has to reach a minimum.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

   typedef enum logic [2:0] {
      TXS_IDLE,
      TXS_START,
      TXS_DATA,
      TXS_PARITY,
      TXS_STOP
   } txs_e;

   localparam int SYM_MAX = 8;

   // number of data bits for a length code
   function automatic logic [3:0] sym_bits(input logic [1:0] code);
      return 4'd5 + {2'b00, code};
   endfunction

   // mask of the data bits that are sent for a length code
   function automatic logic [SYM_MAX-1:0] sym_mask(input logic [1:0] code);
      return {SYM_MAX{1'b1}} >> (3'd3 - {1'b0, code});
   endfunction

endpackage

// File: rtl/uart_tx_timer.sv
module uart_tx_timer #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);

   logic [DIV_W-1:0] cnt;

   assign tick = run && (cnt == div);

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (!run || tick)
         cnt <= '0;
      else
         cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
   parameter int DEPTH  = 16,
   parameter int DATA_W = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       clr,
   input  logic                       wr_en,
   input  logic [DATA_W-1:0]          wr_data,
   input  logic                       rd_en,
   output logic [DATA_W-1:0]          rd_data,
   output logic [$clog2(DEPTH+1)-1:0] level,
   input  logic                       ovf_clr,
   output logic                       ovf
);

   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int LVL_W = $clog2(DEPTH+1);
   localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH-1);
   localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wp, rp;
   logic              full, push, pop, drop;

   assign full = (level == FULL_LVL);
   assign push = wr_en && !clr && !full;
   assign drop = wr_en && !clr && full;
   assign pop  = rd_en && !clr && (level != '0);
   assign rd_data = mem[rp];

   always_ff @(posedge clk) begin
      if (push)
         mem[wp] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         level <= '0;
      end else if (clr) begin
         wp    <= '0;
         rp    <= '0;
         level <= '0;
      end else begin
         if (push)
            wp <= (wp == LAST_PTR) ? '0 : wp + 1'b1;
         if (pop)
            rp <= (rp == LAST_PTR) ? '0 : rp + 1'b1;
         case ({push, pop})
            2'b10:   level <= level + 1'b1;
            2'b01:   level <= level - 1'b1;
            default: level <= level;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         ovf <= 1'b0;
      else
         ovf <= (ovf && !ovf_clr) || drop;
   end

   AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (level == '0)); // R7
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !clr && !rd_en && full) |=> (level == FULL_LVL)); // R8
   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !ovf_clr) |=> ovf); // R8
   AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      level <= FULL_LVL); // R3

endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
   import uart_tx_pkg::*;
#(
   parameter int DIV_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [DIV_W-1:0]   div,
   input  logic [1:0]         char_len,
   input  logic               par_en,
   input  logic               par_odd,
   input  logic               two_stop,
   input  logic               go,
   input  logic               avail,
   input  logic [SYM_MAX-1:0] din,
   output logic               take,
   output logic               line,
   output logic               idle
);

   txs_e               state;
   logic [SYM_MAX-1:0] sh;
   logic [2:0]         bidx;
   logic               sidx;
   logic               pbit;
   logic               tick;
   logic               last_data;
   logic               end_stop;
   logic [SYM_MAX-1:0] din_m;

   uart_tx_timer #(.DIV_W(DIV_W)) u_bit_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (state != TXS_IDLE),
      .div   (div),
      .tick  (tick)
   );

   assign din_m     = din & sym_mask(char_len);
   assign last_data = (bidx == 3'(sym_bits(char_len) - 4'd1));
   assign end_stop  = (state == TXS_STOP) && tick && (sidx == two_stop);
   assign take      = go && avail && ((state == TXS_IDLE) || end_stop);
   assign idle      = (state == TXS_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= TXS_IDLE;
         sh    <= '0;
         bidx  <= '0;
         sidx  <= 1'b0;
         pbit  <= 1'b0;
      end else if (take) begin
         state <= TXS_START;
         sh    <= din_m;
         pbit  <= (^din_m) ^ par_odd;
         bidx  <= '0;
         sidx  <= 1'b0;
      end else if (tick) begin
         case (state)
            TXS_START: state <= TXS_DATA;
            TXS_DATA: begin
               sh <= sh >> 1;
               if (last_data)
                  state <= par_en ? TXS_PARITY : TXS_STOP;
               else
                  bidx <= bidx + 1'b1;
            end
            TXS_PARITY: state <= TXS_STOP;
            TXS_STOP: begin
               if (sidx == two_stop)
                  state <= TXS_IDLE;
               else
                  sidx <= 1'b1;
            end
            default: state <= TXS_IDLE;
         endcase
      end
   end

   always_comb begin
      case (state)
         TXS_START:  line = 1'b0;
         TXS_DATA:   line = sh[0];
         TXS_PARITY: line = pbit;
         default:    line = 1'b1;
      endcase
   end

   AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == TXS_IDLE) && !go) |=> (state == TXS_IDLE)); // R4
   AST_START_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> (state == TXS_START)); // R2

endmodule

// File: rtl/uart_tx_path.sv
module uart_tx_path
   import uart_tx_pkg::*;
#(
   parameter int DEPTH   = 16,
   parameter int DIV_W   = 16,
   parameter bit OUT_REG = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [7:0]                 wr_data,
   input  logic                       fifo_clr,
   input  logic                       ovf_clr,
   input  logic                       tx_en,
   input  logic                       brk,
   input  logic [DIV_W-1:0]           baud_div,
   input  logic [1:0]                 char_len,
   input  logic                       par_en,
   input  logic                       par_odd,
   input  logic                       two_stop,
   input  logic [$clog2(DEPTH+1)-1:0] thresh,
   input  logic                       mask_empty,
   input  logic                       mask_below,
   output logic                       txd,
   output logic [$clog2(DEPTH+1)-1:0] level,
   output logic                       empty_st,
   output logic                       below_st,
   output logic                       ovf_st,
   output logic                       irq
);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("uart_tx_path: DEPTH must be at least 2");
      end
      if (DIV_W < 1) begin : g_bad_div
         $error("uart_tx_path: DIV_W must be at least 1");
      end
   endgenerate

   logic [SYM_MAX-1:0] head;
   logic               take, line, sh_idle;
   logic               rec_busy, rec_tick, go;

   uart_tx_fifo #(.DEPTH(DEPTH), .DATA_W(SYM_MAX)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (fifo_clr),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .rd_en   (take),
      .rd_data (head),
      .level   (level),
      .ovf_clr (ovf_clr),
      .ovf     (ovf_st)
   );

   // one bit time of enforced idle after a break is released
   uart_tx_timer #(.DIV_W(DIV_W)) u_rec_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (rec_busy && !brk),
      .div   (baud_div),
      .tick  (rec_tick)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         rec_busy <= 1'b0;
      else if (brk)
         rec_busy <= 1'b1;
      else if (rec_tick)
         rec_busy <= 1'b0;
   end

   assign go = tx_en && !brk && !rec_busy;

   uart_tx_shift #(.DIV_W(DIV_W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .div      (baud_div),
      .char_len (char_len),
      .par_en   (par_en),
      .par_odd  (par_odd),
      .two_stop (two_stop),
      .go       (go),
      .avail    (level != '0),
      .din      (head),
      .take     (take),
      .line     (line),
      .idle     (sh_idle)
   );

   generate
      if (OUT_REG) begin : g_txd_reg
         logic txd_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               txd_q <= 1'b1;
            else
               txd_q <= line && !brk;
         end
         assign txd = txd_q;
      end else begin : g_txd_comb
         assign txd = line && !brk;
      end
   endgenerate

   assign empty_st = (level == '0) && sh_idle;
   assign below_st = (level < thresh);
   assign irq      = (empty_st && mask_empty) || (below_st && mask_below);

   AST_BREAK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (brk && $past(brk) && $past(rst_n)) |-> !txd); // R5
   AST_RECOVER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(brk) && !brk && $past(rst_n)) |-> !take); // R6
   AST_DRAINED_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> !empty_st); // R9

endmodule

// File: tb/test_uart_tx_path.sv
module test_uart_tx_path;

   localparam int DEPTH = 16;
   localparam int DIV_W = 16;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic [7:0]        wr_data = '0;
   logic              fifo_clr = 1'b0;
   logic              ovf_clr = 1'b0;
   logic              tx_en = 1'b0;
   logic              brk = 1'b0;
   logic [DIV_W-1:0]  baud_div = 16'd3;
   logic [1:0]        char_len = 2'd3;
   logic              par_en = 1'b0;
   logic              par_odd = 1'b0;
   logic              two_stop = 1'b0;
   logic [4:0]        thresh = '0;
   logic              mask_empty = 1'b0;
   logic              mask_below = 1'b0;
   logic              txd;
   logic [4:0]        level;
   logic              empty_st, below_st, ovf_st, irq;

   int errors = 0;
   int checks = 0;
   int cyc = 0;
   int D = 3;

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   uart_tx_path #(.DEPTH(DEPTH), .DIV_W(DIV_W)) i_uart_tx_path (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .fifo_clr(fifo_clr), .ovf_clr(ovf_clr), .tx_en(tx_en), .brk(brk),
      .baud_div(baud_div), .char_len(char_len), .par_en(par_en),
      .par_odd(par_odd), .two_stop(two_stop), .thresh(thresh),
      .mask_empty(mask_empty), .mask_below(mask_below), .txd(txd),
      .level(level), .empty_st(empty_st), .below_st(below_st),
      .ovf_st(ovf_st), .irq(irq)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic push(input logic [7:0] b);
      wr_data = b;
      wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   function automatic logic [7:0] dmask(input int code);
      return 8'hFF >> (3 - code);
   endfunction

   function automatic logic exp_par(input logic [7:0] d, input int code, input logic odd);
      return (^(d & dmask(code))) ^ odd;
   endfunction

   function automatic int frame_len(input int code, input int pe, input int ts);
      return 1 + 5 + code + pe + 1 + ts;
   endfunction

   task automatic wait_start(output int t, output bit ok);
      ok = 1'b0;
      t = 0;
      for (int i = 0; i < 4000; i++) begin
         if (txd === 1'b0) begin
            ok = 1'b1;
            t = cyc;
            return;
         end
         @(negedge clk);
      end
   endtask

   // called on the falling edge where the start bit was first seen
   task automatic recv(input int code, input int pe, input int ts,
                       output logic [7:0] d, output logic pb, output bit fr_ok);
      fr_ok = 1'b1;
      d = '0;
      pb = 1'b0;
      repeat ((D + 1) / 2) @(negedge clk);
      if (txd !== 1'b0) fr_ok = 1'b0;
      for (int i = 0; i < 5 + code; i++) begin
         repeat (D + 1) @(negedge clk);
         d[i] = txd;
      end
      if (pe != 0) begin
         repeat (D + 1) @(negedge clk);
         pb = txd;
      end
      for (int s = 0; s <= ts; s++) begin
         repeat (D + 1) @(negedge clk);
         if (txd !== 1'b1) fr_ok = 1'b0;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [7:0] q [4];
      logic [7:0] d;
      logic       pb;
      bit         ok, fok;
      int         t, tprev, code, pe, po, ts, k, cnt;

      void'($urandom(32'h5A17));
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state
      chk(txd === 1'b1, "R1 txd", int'(txd), 1);
      chk(level == 0, "R1 level", int'(level), 0);
      chk(empty_st === 1'b1, "R1 empty", int'(empty_st), 1);
      chk(ovf_st === 1'b0, "R1 ovf", int'(ovf_st), 0);

      // queue with transmit disabled
      for (int i = 0; i < 5; i++) push(8'h30 + 8'(i));
      chk(level == 5, "R3 level after 5 writes", int'(level), 5);
      chk(empty_st === 1'b0, "R9 not empty with data", int'(empty_st), 0);
      cnt = 0;
      for (int i = 0; i < 50; i++) begin
         @(negedge clk);
         if (txd !== 1'b1) cnt++;
      end
      chk(cnt == 0, "R4 no frame while disabled", cnt, 0);
      chk(level == 5, "R4 level kept while disabled", int'(level), 5);

      // threshold and interrupt routing
      thresh = 5'd8;
      mask_below = 1'b1;
      @(negedge clk);
      chk(below_st === 1'b1, "R10 below at 5<8", int'(below_st), 1);
      chk(irq === 1'b1, "R11 irq from below", int'(irq), 1);
      mask_below = 1'b0;
      mask_empty = 1'b1;
      @(negedge clk);
      chk(irq === 1'b0, "R11 irq empty masked-in but not empty", int'(irq), 0);

      // fill and overflow
      for (int i = 0; i < 11; i++) push(8'h40 + 8'(i));
      chk(level == 16, "R3 level full", int'(level), 16);
      chk(below_st === 1'b0, "R10 not below at 16", int'(below_st), 0);
      chk(ovf_st === 1'b0, "R8 no ovf at exactly full", int'(ovf_st), 0);
      push(8'hEE);
      chk(level == 16, "R8 dropped write", int'(level), 16);
      chk(ovf_st === 1'b1, "R8 ovf set", int'(ovf_st), 1);
      repeat (5) @(negedge clk);
      chk(ovf_st === 1'b1, "R8 ovf sticky", int'(ovf_st), 1);
      ovf_clr = 1'b1;
      @(negedge clk);
      ovf_clr = 1'b0;
      chk(ovf_st === 1'b0, "R8 ovf cleared", int'(ovf_st), 0);

      // clear wins over a write
      fifo_clr = 1'b1;
      wr_en = 1'b1;
      wr_data = 8'h77;
      @(negedge clk);
      fifo_clr = 1'b0;
      wr_en = 1'b0;
      chk(level == 0, "R7 clear empties", int'(level), 0);
      chk(empty_st === 1'b1, "R9 empty after clear", int'(empty_st), 1);
      chk(irq === 1'b1, "R11 irq from empty", int'(irq), 1);
      mask_empty = 1'b0;

      // pause mid-stream and resume, 8N1
      D = 3; baud_div = 16'(D);
      push(8'hA5);
      push(8'h3C);
      tx_en = 1'b1;
      wait_start(t, ok);
      chk(ok, "R4 frame starts when enabled", int'(ok), 1);
      tx_en = 1'b0;
      recv(3, 0, 0, d, pb, fok);
      chk(fok && d == 8'hA5, "R2 first char", int'(d), 8'hA5);
      cnt = 0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (txd !== 1'b1) cnt++;
      end
      chk(cnt == 0, "R4 halted after current frame", cnt, 0);
      chk(level == 1, "R4 held char kept", int'(level), 1);
      tx_en = 1'b1;
      wait_start(t, ok);
      recv(3, 0, 0, d, pb, fok);
      chk(ok && fok && d == 8'h3C, "R4 resumed char", int'(d), 8'h3C);
      repeat (D + 2) @(negedge clk);

      // break
      brk = 1'b1;
      push(8'h5E);
      cnt = 0;
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         if (txd !== 1'b0) cnt++;
      end
      chk(cnt <= 1, "R5 line low during break", cnt, 0);
      chk(level == 1, "R5 no frame during break", int'(level), 1);
      brk = 1'b0;
      cnt = 0;
      for (int i = 0; i < 100; i++) begin
         @(negedge clk);
         if (txd === 1'b0) break;
         cnt++;
      end
      chk(cnt >= D + 1, "R6 idle gap after break", cnt, D + 1);
      wait_start(t, ok);
      recv(3, 0, 0, d, pb, fok);
      chk(ok && fok && d == 8'h5E, "R6 char after break", int'(d), 8'h5E);
      repeat (D + 2) @(negedge clk);

      // random frame formats
      for (int r = 0; r < 8; r++) begin
         tx_en = 1'b0;
         code = int'($urandom_range(0, 3));
         pe = int'($urandom_range(0, 1));
         po = int'($urandom_range(0, 1));
         ts = int'($urandom_range(0, 1));
         D = int'($urandom_range(1, 5));
         k = int'($urandom_range(2, 4));
         char_len = 2'(code); par_en = pe[0]; par_odd = po[0];
         two_stop = ts[0]; baud_div = 16'(D);
         thresh = 5'($urandom_range(0, 6));
         mask_empty = 1'($urandom_range(0, 1));
         mask_below = 1'($urandom_range(0, 1));
         for (int i = 0; i < k; i++) begin
            q[i] = 8'($urandom_range(0, 255));
            push(q[i]);
         end
         chk(level == 5'(k), "R3 level after random writes", int'(level), k);
         chk(below_st == (k < int'(thresh)), "R10 random threshold",
             int'(below_st), int'(k < int'(thresh)));
         chk(irq == (mask_below && (k < int'(thresh))), "R11 random irq",
             int'(irq), int'(mask_below && (k < int'(thresh))));
         tx_en = 1'b1;
         tprev = 0;
         for (int i = 0; i < k; i++) begin
            wait_start(t, ok);
            chk(ok, "R2 start bit seen", int'(ok), 1);
            if (i == 0)
               chk(level == 5'(k - 1), "R3 level drops on take", int'(level), k - 1);
            else
               chk(t - tprev == frame_len(code, pe, ts) * (D + 1), "R2 frame spacing",
                   t - tprev, frame_len(code, pe, ts) * (D + 1));
            if (i == k - 1)
               chk(empty_st === 1'b0, "R9 not empty while last shifts", int'(empty_st), 0);
            tprev = t;
            recv(code, pe, ts, d, pb, fok);
            chk(fok, "R2 start/stop levels", int'(fok), 1);
            chk(d == (q[i] & dmask(code)), "R2 data bits", int'(d), int'(q[i] & dmask(code)));
            if (pe != 0)
               chk(pb == exp_par(q[i], code, po[0]), "R2 parity bit", int'(pb),
                   int'(exp_par(q[i], code, po[0])));
         end
         repeat (D + 1) @(negedge clk);
         chk(empty_st === 1'b1, "R9 empty after drain", int'(empty_st), 1);
         chk(irq == (mask_empty || (mask_below && thresh != 0)), "R11 irq after drain",
             int'(irq), int'(mask_empty || (mask_below && thresh != 0)));
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule